// File: doc/BRIEF.md
# Arbitrated Local Bus Write Master

This block turns single write requests from a host-side valid/ready port into write cycles on an external 16-bit local bus with a 20-bit address, using separate active-low read and write strobes. Before it drives the bus it must own it. When the external grant-status input is low at the moment a request is taken, the block raises a hold request and waits for hold acknowledge. It then keeps the bus for a programmable tenure window and returns it when that window closes. When grant status is already high at acceptance, the handshake is skipped and the write cycle starts on the next clock.

Inside a tenure window, further requests run one after another with no new arbitration. A write that is still running when the window expires completes before the bus is released. Every bus output has an output enable, so the pads can be three-stated whenever the block is not the owner.

Top module: `lbus_wr_master`

## Requirements
- R1: While waiting for hold acknowledge, hold_o is high and la_oe_o, ld_oe_o and strb_oe_o are all low. No bus output is enabled until hold acknowledge has been sampled on a rising clock edge.
- R2: Once hold acknowledge is sampled, the block owns the bus for exactly the configured tenure in clocks. Owned clocks are those where hold_o and hold acknowledge are both high. After that it drops hold_o, with all output enables low, unless a write is still in progress.
- R3: A tenure setting below 32 behaves as 32.
- R4: If grant_i is high when a request is accepted from idle, hold_o stays low and the write cycle starts on the next clock.
- R5: A write cycle lasts L clocks, where L is cyc_len_i (sampled when the cycle starts) and values below 3 act as 3. A setting of 4 gives 4 clocks, and wr_n_o stays low for L-2 consecutive clocks.
- R6: In cycle clock k (1..L), la_oe_o is high for every k, ld_oe_o is high for k>=2, wr_n_o is low for 2<=k<=L-1, and rd_n_o stays high.
- R7: done_o is a single-clock pulse in clock L, the clock in which wr_n_o returns high.
- R8: A request accepted between cycles inside the tenure window starts a new cycle with no new hold handshake. hold_o stays high throughout.
- R9: A cycle in progress when the tenure expires runs to clock L. The bus is released at the end of that clock, so the owned time exceeds the tenure.
- R10: ready_o is high in idle and between cycles while tenure remains. It is low while waiting for acknowledge, during a cycle, and once the tenure has expired.
- R11: During a cycle, la_o carries the latched address, with bit 0 forced to 1 when be_i was 2'b10 (upper byte only). bhe_n_o equals the inverse of be_i[1]. ld_o carries the latched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host write request valid |
| ready_o | output | 1 | Block can accept a request this clock |
| addr_i | input | 20 | Host write address |
| data_i | input | 16 | Host write data |
| be_i | input | 2 | Byte enables, bit 1 = upper byte |
| done_o | output | 1 | One-clock write completion pulse |
| ten_cfg_i | input | 20 | Tenure length in clocks (min 32) |
| cyc_len_i | input | 4 | Write cycle length in clocks (min 3) |
| grant_i | input | 1 | Bus already granted status |
| hold_o | output | 1 | Hold request to the arbiter |
| hlda_i | input | 1 | Hold acknowledge from the arbiter |
| la_o | output | 20 | Local address |
| la_oe_o | output | 1 | Enable for address and byte-high enable |
| bhe_n_o | output | 1 | Active-low byte-high enable |
| ld_o | output | 16 | Local write data |
| ld_oe_o | output | 1 | Enable for data bus |
| rd_n_o | output | 1 | Active-low read strobe (held inactive) |
| wr_n_o | output | 1 | Active-low write strobe |
| strb_oe_o | output | 1 | Enable for read and write strobes |

## Verification
The assertions check on every clock the properties that need no history. All enables stay low during the acknowledge wait. A low write strobe always sits inside an enabled data phase. done_o follows a low strobe and never lasts two clocks. A grant-path start never raises hold. An expired idle window drops hold on the next clock. The tenure load is never below the floor. The exact tenure counts (clamped, unclamped and overrun by a straddling cycle), the strobe run lengths for several cycle settings, back-to-back writes without re-arbitration, and the byte-lane encoding can only be shown by the bench scenarios, compared against the behavioural model clock by clock.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HREQ = 2'd1,
    ST_OWN  = 2'd2,
    ST_CYC  = 2'd3
  } lbw_state_e;
endpackage

// File: rtl/lbw_tenure.sv
module lbw_tenure #(
  parameter int CNT_W   = 20,
  parameter int MIN_TEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cfg_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TEN);

  logic [CNT_W-1:0] cnt_q, ld_val;

  // counts owned clocks: N-1 down to 0
  assign ld_val    = (cfg_i < FLOOR) ? FLOOR - CNT_W'(1) : cfg_i - CNT_W'(1);
  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= ld_val;
    else if (en_i && !expired_o) cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_TEN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q >= FLOOR - CNT_W'(1))); // R3
endmodule

// File: rtl/lbw_cycle.sv
module lbw_cycle #(
  parameter int LEN_W   = 4,
  parameter int MIN_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o,
  output logic             last_o,
  output logic             data_oe_o,
  output logic             wr_n_o
);
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] cnt_q, len_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      len_q <= LMIN;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= LEN_W'(1);
      len_q <= (len_i < LMIN) ? LMIN : len_i;
    end else if (act_q) begin
      if (last_o) act_q <= 1'b0;
      else        cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign active_o  = act_q;
  assign last_o    = act_q && (cnt_q == len_q);
  assign data_oe_o = act_q && (cnt_q >= LEN_W'(2));
  assign wr_n_o    = !(data_oe_o && !last_o);

  AST_STRB_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> data_oe_o); // R6
  AST_LAST_AFTER_STRB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> $past(!wr_n_o)); // R7
endmodule

// File: rtl/lbus_wr_master.sv
module lbus_wr_master
  import lbw_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int TEN_W   = 20,
  parameter int LEN_W   = 4,
  parameter int MIN_TEN = 32,
  parameter int MIN_LEN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             ready_o,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [DW/8-1:0]  be_i,
  output logic             done_o,
  input  logic [TEN_W-1:0] ten_cfg_i,
  input  logic [LEN_W-1:0] cyc_len_i,
  input  logic             grant_i,
  output logic             hold_o,
  input  logic             hlda_i,
  output logic [AW-1:0]    la_o,
  output logic             la_oe_o,
  output logic             bhe_n_o,
  output logic [DW-1:0]    ld_o,
  output logic             ld_oe_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             strb_oe_o
);
  localparam int BW = DW / 8;

  lbw_state_e      state_q, state_d;
  logic            arb_own_q, arb_own_d;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [BW-1:0]   be_q;
  logic            take, cyc_start, ten_load, ten_exp;
  logic            cyc_act, cyc_last, cyc_doe, cyc_wr_n;
  logic            hi_only;

  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_OWN && !ten_exp);
  assign take    = req_i && ready_o;

  always_comb begin
    state_d   = state_q;
    cyc_start = 1'b0;
    ten_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (take) begin
        cyc_start = grant_i;
        state_d   = grant_i ? ST_CYC : ST_HREQ;
      end
      ST_HREQ: if (hlda_i) begin
        ten_load  = 1'b1;
        cyc_start = 1'b1;
        state_d   = ST_CYC;
      end
      ST_OWN: if (take) begin
        cyc_start = 1'b1;
        state_d   = ST_CYC;
      end else if (ten_exp) begin
        state_d   = ST_IDLE;
      end
      ST_CYC: if (cyc_last)
        state_d = (arb_own_q && !ten_exp) ? ST_OWN : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    arb_own_d = arb_own_q;
    if (ten_load)                arb_own_d = 1'b1;
    else if (state_d == ST_IDLE) arb_own_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      arb_own_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      be_q      <= '0;
    end else begin
      state_q   <= state_d;
      arb_own_q <= arb_own_d;
      if (take) begin
        addr_q <= addr_i;
        data_q <= data_i;
        be_q   <= be_i;
      end
    end
  end

  lbw_tenure #(.CNT_W(TEN_W), .MIN_TEN(MIN_TEN)) u_tenure (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ten_load),
    .en_i     (arb_own_q),
    .cfg_i    (ten_cfg_i),
    .expired_o(ten_exp)
  );

  lbw_cycle #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_cycle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start),
    .len_i    (cyc_len_i),
    .active_o (cyc_act),
    .last_o   (cyc_last),
    .data_oe_o(cyc_doe),
    .wr_n_o   (cyc_wr_n)
  );

  // upper-byte-only access puts an odd address on the bus
  generate
    if (BW > 1) begin : g_lanes
      assign hi_only = be_q[BW-1] && !(|be_q[BW-2:0]);
    end else begin : g_single
      assign hi_only = 1'b0;
    end
  endgenerate

  assign hold_o    = (state_q == ST_HREQ) || arb_own_q;
  assign strb_oe_o = (state_q == ST_OWN) || (state_q == ST_CYC);
  assign la_oe_o   = cyc_act;
  assign la_o      = {addr_q[AW-1:1], addr_q[0] | hi_only};
  assign bhe_n_o   = !be_q[BW-1];
  assign ld_oe_o   = cyc_doe;
  assign ld_o      = data_q;
  assign rd_n_o    = 1'b1;
  assign wr_n_o    = cyc_wr_n;
  assign done_o    = cyc_last;

  AST_NO_DRIVE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HREQ) |-> (!la_oe_o && !ld_oe_o && !strb_oe_o)); // R1
  AST_RELEASE_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OWN && ten_exp && !req_i) |=> (!hold_o && !strb_oe_o)); // R2
  AST_GRANT_NO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && grant_i) |=> (!hold_o && la_oe_o)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    la_oe_o |-> !ready_o); // R10
endmodule

// File: tb/lbus_wr_master_tb.sv
module lbus_wr_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic        ready;
  logic [19:0] addr;
  logic [15:0] data;
  logic [1:0]  be;
  logic        done;
  logic [19:0] ten_cfg;
  logic [3:0]  cyc_len;
  logic        grant;
  logic        hold;
  logic        hlda = 1'b0;
  logic [19:0] la;
  logic        la_oe, bhe_n, ld_oe, rd_n, wr_n, strb_oe;
  logic [15:0] ld;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lbus_wr_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .addr_i(addr), .data_i(data), .be_i(be), .done_o(done),
    .ten_cfg_i(ten_cfg), .cyc_len_i(cyc_len), .grant_i(grant),
    .hold_o(hold), .hlda_i(hlda), .la_o(la), .la_oe_o(la_oe),
    .bhe_n_o(bhe_n), .ld_o(ld), .ld_oe_o(ld_oe), .rd_n_o(rd_n),
    .wr_n_o(wr_n), .strb_oe_o(strb_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 wait ack, 2 owned idle, 3 writing
  int m_st = 0, m_c = 0, m_len = 3, m_t = 0;
  bit m_arb = 0;
  logic [19:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic [1:0]  m_be   = '0;

  function automatic int clamp_len(int v);
    return (v < 3) ? 3 : v;
  endfunction
  function automatic int clamp_ten(int v);
    return (v < 32) ? 32 : v;
  endfunction
  function automatic bit m_ready();
    return (m_st == 0) || (m_st == 2 && m_t > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_c = 0; m_t = 0; m_arb = 0; m_len = 3;
      m_addr = '0; m_data = '0; m_be = '0;
    end else begin
      bit tk;
      int t_old;
      tk = req && m_ready();
      t_old = m_t;
      if (m_arb && m_t > 0) m_t = m_t - 1;
      if (tk) begin m_addr = addr; m_data = data; m_be = be; end
      case (m_st)
        0: if (tk) begin
             if (grant) begin m_st = 3; m_c = 1; m_len = clamp_len(int'(cyc_len)); end
             else m_st = 1;
           end
        1: if (hlda) begin
             m_st = 3; m_c = 1; m_arb = 1; m_len = clamp_len(int'(cyc_len));
             m_t = clamp_ten(int'(ten_cfg)) - 1;
           end
        2: if (tk) begin m_st = 3; m_c = 1; m_len = clamp_len(int'(cyc_len)); end
           else if (t_old == 0) begin m_st = 0; m_arb = 0; end
        default: if (m_c == m_len) begin
             if (m_arb && t_old > 0) m_st = 2;
             else begin m_st = 0; m_arb = 0; end
           end else m_c = m_c + 1;
      endcase
    end
  end

  // per-clock compare, hold-ack responder and scenario monitors
  int  cyc_cnt = 0, own_cnt = 0, hold_rises = 0, wr_run = 0, exp_run = 2, ack_wait = 0;
  bit  prev_hold = 0, grant_hold_seen = 0;

  always @(negedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (rst_n) begin
      bit act, eld;
      act = (m_st == 3);
      eld = act && m_c >= 2;
      chk("R10 ready", ready, m_ready());
      chk("R2 hold", hold, (m_st == 1) || (m_st == 2) || (m_st == 3 && m_arb));
      chk("R1 strb_oe", strb_oe, (m_st == 2) || (m_st == 3));
      chk("R6 la_oe", la_oe, act);
      chk("R6 ld_oe", ld_oe, eld);
      chk("R6 wr_n", wr_n, !(eld && m_c < m_len));
      chk("R6 rd_n", rd_n, 1'b1);
      chk("R7 done", done, act && m_c == m_len);
      if (act) begin
        chk("R11 la", la, {m_addr[19:1], m_addr[0] | (m_be == 2'b10)});
        chk("R11 bhe_n", bhe_n, !m_be[1]);
      end
      if (eld) chk("R11 ld", ld, m_data);
      if (hold && hlda) own_cnt++;
      if (hold && !prev_hold) hold_rises++;
      if (hold && grant) grant_hold_seen = 1;
      prev_hold = hold;
      if (!wr_n) wr_run++;
      else if (wr_run > 0) begin
        chk("R5 strobe run", wr_run, exp_run);
        wr_run = 0;
      end
      if (!hold) begin hlda <= 1'b0; ack_wait = 0; end
      else if (!hlda) begin
        ack_wait++;
        if (ack_wait >= 3) hlda <= 1'b1;
      end
    end
  end

  task automatic wr(logic [19:0] a, logic [15:0] d, logic [1:0] b);
    req = 1'b1; addr = a; data = d; be = b;
    forever begin
      if (ready) begin
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (hold || strb_oe || !ready);
  endtask

  task automatic clr_mon();
    own_cnt = 0; hold_rises = 0; grant_hold_seen = 0;
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; addr = '0; data = '0; be = 2'b11;
    ten_cfg = 20'd32; cyc_len = 4'd4; grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", ready, 1'b1);
    chk("R1 reset hold", hold, 1'b0);
    chk("R1 reset oe", {la_oe, ld_oe, strb_oe}, 3'b000);

    // R4/R5: grant already held, 4-clock cycle
    clr_mon(); grant = 1'b1; exp_run = 2;
    wr(20'h12344, 16'hbeef, 2'b11);
    wait_idle();
    chk("R4 no hold on grant path", grant_hold_seen, 1'b0);
    // R5: short length clamps to 3
    cyc_len = 4'd1; exp_run = 1;
    wr(20'h00010, 16'h1111, 2'b01);
    wait_idle();
    cyc_len = 4'd7; exp_run = 5;
    wr(20'h00020, 16'h2222, 2'b10);
    wait_idle();
    grant = 1'b0;

    // R1/R3: arbitration, tenure 5 clamps to 32
    clr_mon(); cyc_len = 4'd4; exp_run = 2; ten_cfg = 20'd5;
    wr(20'h0abc0, 16'h5a5a, 2'b11);
    wait_idle();
    chk("R3 clamped tenure", own_cnt, 32);
    chk("R1 one handshake", hold_rises, 1);

    // R2/R8: tenure 40, two writes back to back, R11 upper-byte-only
    clr_mon(); ten_cfg = 20'd40;
    wr(20'h44440, 16'h0102, 2'b10);
    wr(20'h44442, 16'h0304, 2'b01);
    wait_idle();
    chk("R2 tenure length", own_cnt, 40);
    chk("R8 no re-arbitration", hold_rises, 1);

    // R9: cycle straddles tenure expiry
    clr_mon(); ten_cfg = 20'd32; cyc_len = 4'd5; exp_run = 3;
    for (int i = 0; i < 6; i++) wr(20'h10000 + 20'(i * 2), 16'(16'h7000 + i), 2'b11);
    wait_idle();
    chk("R9 overrun completes", own_cnt > 32, 1'b1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule